// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes into asynchronous serial frames on a single transmit line. A one-byte holding register takes each byte through a valid/ready handshake, and a shifter sends it as a low start bit, 5 to 8 data bits (least significant first), an optional parity bit and 1, 1.5 or 2 stop bits. The frame shape comes from an 8-bit line control word that the surrounding logic holds steady. Bit timing comes from an external baud tick: every bit lasts 16 ticks.

The line control word also carries a break request. While break is set the line is held low at once, whatever the shifter was doing. The frame in flight is abandoned, and no new frame starts until break is cleared. A byte still in the holding register is kept and goes out, with a fresh start bit, after the break ends.

Back-pressure: `in_ready_o` is high exactly when the holding register is empty. A byte is taken on a rising clock edge where both `in_valid_i` and `in_ready_o` are high. The upstream side must hold `in_valid_i` and `in_data_i` steady while ready is low. The holding register hands its byte to the shifter in the first cycle the shifter is idle and break is clear, and it can take a new byte while that frame is still shifting.

Top module: `uart_tx_framer`

## Requirements
- R1: Line control bits [1:0] set the data length: 0 sends 5 bits, 1 sends 6, 2 sends 7 and 3 sends 8. Data bits above the chosen length are not sent.
- R2: The idle line is high. A frame starts with one low start bit, and data follows with the least significant bit first. Every start, data and parity bit lasts 16 baud ticks. The first bit period begins in the cycle after the byte leaves the holding register.
- R3: With line control bit 2 clear, the stop level lasts 16 ticks. With bit 2 set it lasts 24 ticks (1.5 stop bits) for a 5-bit length and 32 ticks (2 stop bits) for 6, 7 or 8 bits.
- R4: Line control bit 3 set inserts one parity bit between the last data bit and the stop bits. With bit 3 clear, no parity bit is sent and bits 4 and 5 have no effect.
- R5: With parity on and bit 5 clear, bit 4 set gives even parity (the data bits plus parity hold an even count of ones) and bit 4 clear gives odd parity.
- R6: With parity on and bit 5 set, the parity bit is constant. Bits [5:3] = 3'b101 send 1 and 3'b111 send 0.
- R7: Line control bit 6 set drives the line low in the same cycle. The frame in progress is dropped, and no frame starts while bit 6 stays set. After it clears, a waiting byte goes out as a full new frame.
- R8: `in_ready_o` equals "holding register empty". A handshake fills the register, and ready drops from the next cycle until the shifter takes the byte.
- R9: `thr_empty_o` is high when the holding register is empty. `tx_empty_o` is high only when the holding register is empty and no frame is being shifted out.
- R10: Length, stop and parity settings are sampled when the shifter takes the byte. Changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcr_i | input | 8 | Line control word: length, stop, parity and break fields |
| baud_tick_i | input | 1 | One-cycle pulse, 16 per bit time |
| in_valid_i | input | 1 | Byte offered by upstream |
| in_data_i | input | 8 | Byte to send |
| in_ready_o | output | 1 | Holding register can take a byte |
| txd_o | output | 1 | Serial line, high when idle |
| thr_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and shifter both idle |

## Verification
A handshake is reflected in `in_ready_o` and `thr_empty_o` one cycle after its edge. The byte moves into the shifter on the next edge at which the shifter is idle, and the start bit appears on `txd_o` in the cycle after that. Each later bit changes in the cycle after the 16th (or, for the last stop period, the 24th or 32nd) tick of the current bit. Break is the only path that acts on `txd_o` in the same cycle. The bench keeps a per-tick queue of expected line levels, filled at the modelled load edge and popped on each tick. It compares all four outputs against this queue at every falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } txf_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       long_stop;
    logic       par_on;
    logic       par_even;
    logic       par_stick;
  } txf_cfg_t;

  function automatic txf_cfg_t decode_line_ctrl(input logic [7:0] word);
    txf_cfg_t c;
    c.len_sel   = word[1:0];
    c.long_stop = word[2];
    c.par_on    = word[3];
    c.par_even  = word[4];
    c.par_stick = word[5];
    return c;
  endfunction

endpackage

// File: rtl/txf_hold.sv
module txf_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] dout
);

  logic accept;

  assign in_ready = ~full;
  assign accept   = in_valid & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (accept) begin
      full <= 1'b1;
      dout <= in_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R8
  AST_POP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full); // R8
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> $stable(dout) && full); // R8

endmodule

// File: rtl/txf_parity.sv
module txf_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_sel,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              par_bit
);

  localparam int MIN_LEN = 5;

  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi < MIN_LEN) begin : g_always
        assign masked[gi] = data[gi];
      end else begin : g_sel
        assign masked[gi] = data[gi] & (int'(len_sel) >= gi - MIN_LEN + 1);
      end
    end
  endgenerate

  assign ones_odd = ^masked;

  always_comb begin
    if (par_stick) par_bit = ~par_even;
    else if (par_even) par_bit = ones_odd;
    else par_bit = ~ones_odd;
  end

endmodule

// File: rtl/txf_shift.sv
module txf_shift
  import uart_txf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk,
  input  logic              tick,
  input  logic              byte_avail,
  input  logic [DATA_W-1:0] byte_data,
  input  txf_cfg_t          cfg,
  input  logic              par_in,
  output logic              pop,
  output logic              line_bit,
  output logic              idle
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] STOP1_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] STOP2_LAST = CNT_W'(2 * OVERSAMPLE - 1);

  txf_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  txf_cfg_t          cfg_q;
  logic              par_q;
  logic [IDX_W-1:0]  idx_last;
  logic [CNT_W-1:0]  stop_last;
  logic              bit_done;

  assign idx_last = IDX_W'(4) + IDX_W'(cfg_q.len_sel);
  assign pop      = (state == ST_IDLE) && byte_avail && !brk;
  assign idle     = (state == ST_IDLE);

  always_comb begin
    if (!cfg_q.long_stop) stop_last = STOP1_LAST;
    else if (cfg_q.len_sel == 2'd0) stop_last = STOP15_LAST;
    else stop_last = STOP2_LAST;
  end

  assign bit_done = tick && (cnt == ((state == ST_STOP) ? stop_last : BIT_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (brk) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      if (state != ST_IDLE && tick) begin
        cnt <= bit_done ? '0 : cnt + CNT_W'(1);
      end
      unique case (state)
        ST_IDLE: begin
          if (byte_avail) begin
            state <= ST_START;
            cnt   <= '0;
            idx   <= '0;
            shreg <= byte_data;
            cfg_q <= cfg;
            par_q <= par_in;
          end
        end
        ST_START: if (bit_done) state <= ST_DATA;
        ST_DATA: begin
          if (bit_done) begin
            shreg <= shreg >> 1;
            if (idx == idx_last) state <= cfg_q.par_on ? ST_PAR : ST_STOP;
            else idx <= idx + IDX_W'(1);
          end
        end
        ST_PAR:  if (bit_done) state <= ST_STOP;
        ST_STOP: if (bit_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  AST_BREAK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> state == ST_IDLE); // R7
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> state == ST_START && cnt == '0); // R2
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !brk && state != ST_IDLE |=> $stable(cnt)); // R2
  AST_STOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_STOP |-> cnt <= BIT_LAST); // R3

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        lcr_i,
  input  logic              baud_tick_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              txd_o,
  output logic              thr_empty_o,
  output logic              tx_empty_o
);

  localparam int BRK_POS = 6;

  txf_cfg_t          cfg;
  logic              brk;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              pop;
  logic              par_bit;
  logic              line_bit;
  logic              shift_idle;

  assign cfg = decode_line_ctrl(lcr_i);
  assign brk = lcr_i[BRK_POS];

  txf_hold #(.DATA_W(DATA_W)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid_i),
    .in_data  (in_data_i),
    .in_ready (in_ready_o),
    .pop      (pop),
    .full     (hold_full),
    .dout     (hold_data)
  );

  txf_parity #(.DATA_W(DATA_W)) par_i (
    .data      (hold_data),
    .len_sel   (cfg.len_sel),
    .par_even  (cfg.par_even),
    .par_stick (cfg.par_stick),
    .par_bit   (par_bit)
  );

  txf_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk        (brk),
    .tick       (baud_tick_i),
    .byte_avail (hold_full),
    .byte_data  (hold_data),
    .cfg        (cfg),
    .par_in     (par_bit),
    .pop        (pop),
    .line_bit   (line_bit),
    .idle       (shift_idle)
  );

  assign txd_o       = brk ? 1'b0 : line_bit;
  assign thr_empty_o = ~hold_full;
  assign tx_empty_o  = ~hold_full & shift_idle;

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd_o); // R7
  AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_o |-> thr_empty_o); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_o && !brk |-> txd_o); // R2

endmodule

// File: tb/uart_tx_framer_tb_top.sv
module uart_tx_framer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OS         = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lcr = 8'h03;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, thr_empty, tx_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int divc = 0;
  string cur_req = "R2";

  bit   exp_q[$];
  bit   m_full = 1'b0;
  logic [7:0] m_hold = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_tx_framer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lcr_i       (lcr),
    .baud_tick_i (tick),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .txd_o       (txd),
    .thr_empty_o (thr_empty),
    .tx_empty_o  (tx_empty)
  );

  // Baud tick: one pulse every TICK_DIV clocks, driven away from the edge.
  always @(negedge clk) begin
    divc = (divc + 1) % TICK_DIV;
    tick = (divc == 0);
  end

  function automatic void push_level(bit lvl, int n);
    for (int k = 0; k < n; k++) exp_q.push_back(lvl);
  endfunction

  // Expected waveform, one entry per baud tick, built from the requirements.
  function automatic void build_frame(logic [7:0] d, logic [7:0] l);
    int nb = 5 + int'(l[1:0]);
    int ones = 0;
    bit p;
    push_level(1'b0, OS);
    for (int i = 0; i < nb; i++) begin
      push_level(d[i], OS);
      if (d[i]) ones++;
    end
    if (l[3]) begin
      if (l[5]) p = ~l[4];
      else if (l[4]) p = (ones % 2 == 1);
      else p = (ones % 2 == 0);
      push_level(p, OS);
    end
    if (!l[2]) push_level(1'b1, OS);
    else if (nb == 5) push_level(1'b1, OS + OS / 2);
    else push_level(1'b1, 2 * OS);
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      exp_q.delete();
      m_full = 1'b0;
    end else begin
      acc = in_valid && !m_full;
      if (lcr[6]) exp_q.delete();
      else if (exp_q.size() > 0) begin
        if (tick) void'(exp_q.pop_front());
      end else if (m_full) begin
        build_frame(m_hold, lcr);
        m_full = 1'b0;
      end
      if (acc) begin
        m_full = 1'b1;
        m_hold = in_data;
      end
    end
  end

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the reference queue.
  always @(negedge clk) begin
    logic e_txd;
    if (rst_n) begin
      e_txd = lcr[6] ? 1'b0 : (exp_q.size() > 0 ? exp_q[0] : 1'b1);
      check_bit(cur_req, "txd", txd, e_txd);
      check_bit("R8", "in_ready", in_ready, !m_full);
      check_bit("R9", "thr_empty", thr_empty, !m_full);
      check_bit("R9", "tx_empty", tx_empty, !m_full && exp_q.size() == 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(string req, logic [7:0] l, logic [7:0] d);
    cur_req = req;
    lcr = l;
    send(d);
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R2", "reset txd", txd, 1'b1);
    check_bit("R9", "reset tx_empty", tx_empty, 1'b1);
    check_bit("R8", "reset ready", in_ready, 1'b1);

    // R1: the four data lengths.
    frame("R1", 8'h03, 8'hA5);
    frame("R1", 8'h00, 8'hFF);
    frame("R1", 8'h01, 8'hC6);
    frame("R1", 8'h02, 8'h3B);
    // R2: plain LSB-first pattern.
    frame("R2", 8'h03, 8'h01);
    // R3: long stop for 5-bit and 8-bit words.
    frame("R3", 8'h04, 8'h15);
    frame("R3", 8'h07, 8'h80);
    // R4, R5: odd and even parity.
    frame("R4", 8'h0B, 8'h37);
    frame("R5", 8'h1B, 8'h37);
    frame("R5", 8'h1A, 8'h00);
    frame("R4", 8'h33, 8'h5A); // parity off, bits 4/5 ignored
    // R6: stick mark and space.
    frame("R6", 8'h2B, 8'hF0);
    frame("R6", 8'h3B, 8'hF0);

    // R8, R9: back-to-back bytes; the second waits in the holding register.
    cur_req = "R8";
    lcr = 8'h03;
    send(8'h11);
    send(8'h22);
    @(negedge clk);
    check_bit("R8", "second byte held", in_ready, 1'b0);
    check_bit("R9", "busy tx_empty", tx_empty, 1'b0);
    wait_idle();

    // R10: settings changed mid-frame do not affect it.
    cur_req = "R10";
    lcr = 8'h1F;
    send(8'h69);
    repeat (200) @(negedge clk);
    lcr = 8'h00;
    wait_idle();

    // R7: break cuts a frame; queued byte follows with a fresh frame.
    cur_req = "R7";
    lcr = 8'h03;
    send(8'hC3);
    send(8'h5A);
    repeat (150) @(negedge clk);
    lcr = 8'h43;
    @(negedge clk);
    check_bit("R7", "break low", txd, 1'b0);
    repeat (300) @(negedge clk);
    check_bit("R7", "break held low", txd, 1'b0);
    check_bit("R7", "byte waits in break", in_ready, 1'b0);
    lcr = 8'h03;
    wait_idle();
    check_bit("R7", "line idle after break", txd, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule